// File: doc/BRIEF.md
# Range Translation Cache

This block is a small, fully associative cache of range translations. Each entry maps a contiguous span of virtual page numbers onto an equally long contiguous span of physical page numbers. The physical page is the virtual page plus a signed per-entry displacement, and the whole span shares one protection code. The block is consulted after a miss in the first-level data TLB, in parallel with the second-level TLB. When a range covers the requested page, the block produces one page-sized translation that can be written into the first-level TLB.

Every valid entry is compared at once against the lookup page number with an inclusive bounds test. If several entries overlap, the lowest-index entry supplies the result. The page walker installs new ranges through the fill port. A fill takes the lowest-index free slot, or evicts a round-robin victim when every slot is occupied. A single invalidate-all input empties the cache.

Top module: `range_tlb`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` is low, and any lookup returns a miss.
- R2: A valid entry matches a lookup page V exactly when base <= V <= limit, both bounds inclusive and compared unsigned. Pages base-1 and limit+1 do not match.
- R3: On a hit, `rsp_ppn` equals V plus the entry's 36-bit two's-complement displacement, modulo 2^36, and `rsp_prot` equals the entry's protection code.
- R4: `rsp_valid` is high in exactly the cycle after each cycle where `lk_valid` is high. `rsp_hit` is never high without `rsp_valid`. On a miss, `rsp_ppn` and `rsp_prot` are zero.
- R5: When more than one valid entry matches, the result comes from the lowest-index matching entry.
- R6: A fill is written into the lowest-index invalid slot, so while slots remain free, earlier fills hold lower indices than later ones.
- R7: When all slots are valid, a fill replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on each such eviction.
- R8: `inv_all` clears every entry in one cycle. A fill presented in the same cycle as `inv_all` is discarded.
- R9: A lookup and a fill in the same cycle do not interact: the lookup is answered from the contents held before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vpn | input | 36 | Virtual page number to translate |
| fill_valid | input | 1 | Install a new range this cycle |
| fill_base | input | 36 | First virtual page of the range |
| fill_limit | input | 36 | Last virtual page of the range |
| fill_offset | input | 36 | Signed displacement, physical minus virtual page |
| fill_prot | input | 3 | Protection code of the range |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | A range covered the page |
| rsp_ppn | output | 36 | Generated physical page number |
| rsp_prot | output | 3 | Protection of the matching range |

## Verification
A wrong valid bit or a corrupted bound shows up at the ports on the first lookup that lands in the affected span. The result is a false hit or a false miss one cycle after the strobe. A wrong victim or free-slot choice stays hidden until overlapping ranges or later evictions make slot order visible: the priority rule then returns the wrong range's page or protection, or an evicted range still answers. The bench therefore fills overlapping and boundary-touching ranges and then probes both edges of every span, so each such fault reaches the outputs within a few lookups.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;
    localparam int DEF_ENTRIES = 32;
    localparam int DEF_VPN_W   = 36;
    localparam int DEF_PROT_W  = 3;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rtlb_match.sv
module rtlb_match #(
    parameter int ENTRIES = rtlb_pkg::DEF_ENTRIES,
    parameter int VPN_W   = rtlb_pkg::DEF_VPN_W
) (
    input  logic [VPN_W-1:0]              vpn,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] base,
    input  logic [ENTRIES-1:0][VPN_W-1:0] limit,
    output logic [ENTRIES-1:0]            match
);
    // one inclusive bounds comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (vpn >= base[g]) && (vpn <= limit[g]);
    end
endmodule

// File: rtl/rtlb_first.sv
module rtlb_first #(
    parameter int N  = rtlb_pkg::DEF_ENTRIES,
    localparam int IW = rtlb_pkg::idx_width(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  oh,
    output logic [IW-1:0] idx,
    output logic          any
);
    // lowest set bit wins: scan downward so the last write is the lowest
    always_comb begin
        oh  = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                oh     = '0;
                oh[i]  = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtlb_victim.sv
module rtlb_victim #(
    parameter int N  = rtlb_pkg::DEF_ENTRIES,
    localparam int IW = rtlb_pkg::idx_width(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  valid,
    input  logic          fill_take,
    output logic [IW-1:0] slot,
    output logic [N-1:0]  slot_oh
);
    logic [N-1:0]  free_oh;
    logic [IW-1:0] free_idx;
    logic          any_free;
    logic [IW-1:0] rr_d, rr_q;
    logic          evict;

    rtlb_first #(.N(N)) u_free (
        .req (~valid),
        .oh  (free_oh),
        .idx (free_idx),
        .any (any_free)
    );

    always_comb begin
        evict = fill_take && !any_free;
        rr_d  = rr_q;
        if (evict) begin
            rr_d = (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
        end
        if (any_free) begin
            slot    = free_idx;
            slot_oh = free_oh;
        end else begin
            slot    = rr_q;
            slot_oh = '0;
            slot_oh[rr_q] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rr_q <= '0;
        else        rr_q <= rr_d;
    end

    // R7: the pointer moves by exactly one step on every eviction
    a_r7_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_take && !any_free && rr_q != IW'(N - 1)) |=> (rr_q == $past(rr_q) + 1'b1));
    // R7: the pointer holds when no eviction happens
    a_r7_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_take && !any_free) |=> $stable(rr_q));
    // R6: while free slots exist, the chosen slot is one of them
    a_r6_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (~valid != '0) |-> ((slot_oh & valid) == '0));
endmodule

// File: rtl/range_tlb.sv
module range_tlb #(
    parameter int ENTRIES = rtlb_pkg::DEF_ENTRIES,
    parameter int VPN_W   = rtlb_pkg::DEF_VPN_W,
    parameter int PROT_W  = rtlb_pkg::DEF_PROT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_base,
    input  logic [VPN_W-1:0]  fill_limit,
    input  logic [VPN_W-1:0]  fill_offset,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              inv_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [VPN_W-1:0]  rsp_ppn,
    output logic [PROT_W-1:0] rsp_prot
);
    localparam int IW = rtlb_pkg::idx_width(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][VPN_W-1:0]  base;
        logic [ENTRIES-1:0][VPN_W-1:0]  limit;
        logic [ENTRIES-1:0][VPN_W-1:0]  offset;
        logic [ENTRIES-1:0][PROT_W-1:0] prot;
        logic                           rsp_valid;
        logic                           rsp_hit;
        logic [VPN_W-1:0]               rsp_ppn;
        logic [PROT_W-1:0]              rsp_prot;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] hit_oh;
    logic [IW-1:0]      hit_idx;
    logic               any_hit;
    logic [IW-1:0]      vic_slot;
    logic [ENTRIES-1:0] vic_oh;
    logic               fill_take;

    assign fill_take = fill_valid && !inv_all;

    rtlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
        .vpn   (lk_vpn),
        .valid (s_q.valid),
        .base  (s_q.base),
        .limit (s_q.limit),
        .match (match)
    );

    rtlb_first #(.N(ENTRIES)) u_prio (
        .req (match),
        .oh  (hit_oh),
        .idx (hit_idx),
        .any (any_hit)
    );

    rtlb_victim #(.N(ENTRIES)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (s_q.valid),
        .fill_take (fill_take),
        .slot      (vic_slot),
        .slot_oh   (vic_oh)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = lk_valid;
        s_d.rsp_hit   = lk_valid && any_hit;
        s_d.rsp_ppn   = '0;
        s_d.rsp_prot  = '0;
        if (lk_valid && any_hit) begin
            s_d.rsp_ppn  = lk_vpn + s_q.offset[hit_idx];
            s_d.rsp_prot = s_q.prot[hit_idx];
        end
        if (inv_all) begin
            s_d.valid = '0;
        end else if (fill_valid) begin
            s_d.valid[vic_slot]  = 1'b1;
            s_d.base[vic_slot]   = fill_base;
            s_d.limit[vic_slot]  = fill_limit;
            s_d.offset[vic_slot] = fill_offset;
            s_d.prot[vic_slot]   = fill_prot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_hit   = s_q.rsp_hit;
    assign rsp_ppn   = s_q.rsp_ppn;
    assign rsp_prot  = s_q.rsp_prot;

    // R4: a response follows every strobe, and only a strobe
    a_r4_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    a_r4_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
    // R5: at most one entry selected, and it is a matching one
    a_r5_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_oh));
    a_r5_pick_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_oh & ~match) == '0);
    // R8: invalidate empties the cache on the next edge
    a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (s_q.valid == '0));
    // R6: an accepted fill leaves its slot valid
    a_r6_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        fill_take |=> (s_q.valid != '0));
    // R7: the victim slot is always a single slot
    a_r7_victim_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vic_oh) == 1);
endmodule

// File: tb/tb_range_tlb.sv
module tb_range_tlb;
    localparam int N  = 32;
    localparam int VW = 36;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic          fill_valid = 1'b0;
    logic [VW-1:0] fill_base = '0, fill_limit = '0, fill_offset = '0;
    logic [PW-1:0] fill_prot = '0;
    logic          inv_all = 1'b0;
    logic          rsp_valid, rsp_hit;
    logic [VW-1:0] rsp_ppn;
    logic [PW-1:0] rsp_prot;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    range_tlb dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .fill_valid(fill_valid), .fill_base(fill_base), .fill_limit(fill_limit),
        .fill_offset(fill_offset), .fill_prot(fill_prot),
        .inv_all(inv_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_prot(rsp_prot)
    );

    // reference model built from the requirements
    logic          m_val [N];
    logic [VW-1:0] m_base [N], m_lim [N], m_off [N];
    logic [PW-1:0] m_prot [N];
    int            m_rr;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void m_clear();
        for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    endfunction

    function automatic void m_fill(input logic [VW-1:0] b, l, o, input logic [PW-1:0] p);
        int s;
        s = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_val[i]) s = i;
        if (s < 0) begin
            s = m_rr;
            m_rr = (m_rr + 1) % N;
        end
        m_val[s] = 1'b1; m_base[s] = b; m_lim[s] = l; m_off[s] = o; m_prot[s] = p;
    endfunction

    function automatic void m_look(input logic [VW-1:0] v, output logic h,
                                   output logic [VW-1:0] ppn, output logic [PW-1:0] pr);
        h = 1'b0; ppn = '0; pr = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_val[i] && v >= m_base[i] && v <= m_lim[i]) begin
                h = 1'b1; ppn = v + m_off[i]; pr = m_prot[i];
            end
        end
    endfunction

    task automatic fill(input logic [VW-1:0] b, l, o, input logic [PW-1:0] p);
        fill_valid = 1'b1; fill_base = b; fill_limit = l; fill_offset = o; fill_prot = p;
        m_fill(b, l, o, p);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic invalidate();
        inv_all = 1'b1;
        m_clear();
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    task automatic look(input logic [VW-1:0] v, input string req);
        logic eh; logic [VW-1:0] ep; logic [PW-1:0] epr;
        m_look(v, eh, ep, epr);
        lk_valid = 1'b1; lk_vpn = v;
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, 64'(rsp_valid), 64'(1));
        check(req, 64'(rsp_hit), 64'(eh));
        check(req, 64'(rsp_ppn), 64'(ep));
        check(req, 64'(rsp_prot), 64'(epr));
    endtask

    task automatic t_reset();
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'(0));
        look(36'h0, "R1 empty lookup");
        look(36'hF_FFFF_FFFF, "R1 empty lookup top");
    endtask

    task automatic t_bounds();
        invalidate();
        fill(36'h1000, 36'h10FF, 36'h0_0002_0000, 3'd5);
        look(36'h0FFF, "R2 below base");
        look(36'h1000, "R2 at base");
        look(36'h1080, "R3 middle");
        look(36'h10FF, "R2 at limit");
        look(36'h1100, "R2 above limit");
        fill(36'h7, 36'h7, 36'h0_0000_0010, 3'd2);
        look(36'h7, "R2 single page range");
        look(36'h8, "R2 single page range next");
    endtask

    task automatic t_wrap();
        invalidate();
        fill(36'h5000, 36'h5FFF, 36'hF_FFFF_F000, 3'd1);   // -0x1000
        look(36'h5123, "R3 negative offset");
        fill(36'hF_FFFF_FF00, 36'hF_FFFF_FFFF, 36'h0_0000_0200, 3'd6);
        look(36'hF_FFFF_FFF0, "R3 wrap modulo 2^36");
    endtask

    task automatic t_timing();
        invalidate();
        fill(36'h40, 36'h4F, 36'h100, 3'd3);
        lk_valid = 1'b1; lk_vpn = 36'h41;
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = 36'h90;
        check("R4 back to back first hit", 64'(rsp_hit), 64'(1));
        check("R4 back to back first ppn", 64'(rsp_ppn), 64'h141);
        @(negedge clk);
        lk_valid = 1'b0;
        check("R4 miss valid", 64'(rsp_valid), 64'(1));
        check("R4 miss hit", 64'(rsp_hit), 64'(0));
        check("R4 miss ppn zero", 64'(rsp_ppn), 64'(0));
        check("R4 miss prot zero", 64'(rsp_prot), 64'(0));
        @(negedge clk);
        check("R4 idle no response", 64'(rsp_valid), 64'(0));
    endtask

    task automatic t_overlap();
        invalidate();
        fill(36'd100, 36'd200, 36'd1000, 3'd1);
        fill(36'd150, 36'd250, 36'd5000, 3'd2);
        look(36'd160, "R5 lower index wins");
        look(36'd220, "R5 only second covers");
        invalidate();
        fill(36'd150, 36'd250, 36'd5000, 3'd2);
        fill(36'd100, 36'd200, 36'd1000, 3'd1);
        look(36'd160, "R6 fill order sets slot order");
    endtask

    task automatic t_rr();
        invalidate();
        for (int i = 0; i < N; i++)
            fill(36'(i * 16), 36'(i * 16 + 3), 36'(i + 1), 3'(i));
        look(36'd0, "R7 full before eviction");
        fill(36'h9000, 36'h9000, 36'd7, 3'd7);
        look(36'd0, "R7 slot0 evicted");
        look(36'd16, "R7 slot1 survives");
        look(36'h9000, "R7 new entry hits");
        fill(36'hA000, 36'hA000, 36'd9, 3'd4);
        look(36'd17, "R7 slot1 evicted next");
        look(36'd32, "R7 slot2 survives");
        for (int i = 0; i < N - 2; i++)
            fill(36'h20000 + 36'(i), 36'h20000 + 36'(i), 36'd1, 3'd0);
        fill(36'hB000, 36'hB000, 36'd3, 3'd3);
        look(36'h9000, "R7 pointer wraps to slot0");
        look(36'hA000, "R7 slot1 still after wrap");
    endtask

    task automatic t_inv();
        invalidate();
        fill(36'h300, 36'h3FF, 36'h10, 3'd2);
        look(36'h300, "R8 present before invalidate");
        inv_all = 1'b1;
        fill_valid = 1'b1; fill_base = 36'h500; fill_limit = 36'h5FF;
        fill_offset = 36'h1; fill_prot = 3'd1;
        m_clear();
        @(negedge clk);
        inv_all = 1'b0; fill_valid = 1'b0;
        look(36'h300, "R8 cleared");
        look(36'h500, "R8 concurrent fill dropped");
        fill(36'h600, 36'h600, 36'h0, 3'd5);
        look(36'h600, "R8 slot0 reused after invalidate");
    endtask

    task automatic t_same_cycle();
        logic eh; logic [VW-1:0] ep; logic [PW-1:0] epr;
        invalidate();
        m_look(36'h700, eh, ep, epr);
        lk_valid = 1'b1; lk_vpn = 36'h700;
        fill_valid = 1'b1; fill_base = 36'h700; fill_limit = 36'h7FF;
        fill_offset = 36'h20; fill_prot = 3'd6;
        m_fill(36'h700, 36'h7FF, 36'h20, 3'd6);
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0;
        check("R9 lookup sees old contents", 64'(rsp_hit), 64'(eh));
        check("R9 valid with concurrent fill", 64'(rsp_valid), 64'(1));
        look(36'h700, "R9 fill visible afterwards");
    endtask

    initial begin
        m_clear();
        m_rr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bounds();
        t_wrap();
        t_timing();
        t_overlap();
        t_rr();
        t_inv();
        t_same_cycle();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule